// File: doc/BRIEF.md
# Hexadecimal Floating-Point Multiplier

This block multiplies two 32-bit base-16 floating-point words. Each word holds a sign bit, a 7-bit exponent in excess-64 form that scales by powers of sixteen, and a 24-bit fraction read as six hex digits. The result is a packed, rounded word together with three condition flags: overflow/underflow, negative and positive.

A client presents both operands with a one-cycle `start` pulse. It then waits for the one-cycle `done` pulse, which marks the cycle in which `result` and the flags become valid. Those values stay unchanged until the next `done`. Each operand is first brought to a nonzero leading hex digit. The fraction product is then built digit by digit over several cycles, or in one cycle when the single-cycle variant is selected. After that the product is normalized by whole hex digits, rounded, and range-checked.

Top module: `hfm_mul`

## Requirements
- R1: An operand with a nonzero but unnormalized fraction is first shifted left by whole hex digits until its leading digit (bits 23:20) is nonzero. Its exponent drops by one for each digit shifted.
- R2: If either operand has a zero fraction field (bits 23:0), whatever its sign and exponent, the result is 32'h00000000 and all three flags are 0.
- R3: The result sign (bit 31) is the exclusive OR of the operand signs.
- R4: For nonzero operands, the exponent before rounding is ea + eb - 64 - k, where ea and eb are the normalized operand exponents. Here k is 0 when the 48-bit fraction product has a nonzero top digit and 1 otherwise. The result fraction is the upper 24 bits of the product after it has been shifted by k digits.
- R5: Rounding adds 1 to the 24-bit fraction when the next lower product bit is 1. If this carries out of 24 bits, the fraction becomes 24'h100000 and the exponent rises by one. For example, 32'h403FFFFF times 32'h40400001 gives 32'h40100000.
- R6: A final exponent of 0 or below yields 32'h00000000 with `cc_ovf`=1 and `cc_neg`=`cc_pos`=0.
- R7: A final exponent above 127 yields the sign bit followed by 31 ones, with `cc_ovf`=1, `cc_neg` equal to the sign and `cc_pos` equal to its inverse.
- R8: An in-range nonzero result packs as {sign, exponent[6:0], fraction[23:0]}, with `cc_ovf`=0, `cc_neg` equal to the sign and `cc_pos` equal to its inverse.
- R9: After reset, `done`, `busy`, `result` and all flags are 0. `done` is high for exactly one cycle per accepted operation, and `result` and the flags hold their values until the next `done`.
- R10: A `start` pulse arriving while `busy` is high is ignored. The running operation completes with its own operands, and no extra `done` follows.
- R11: Count the edge that accepts `start` as edge 1. `done` is sampled high after edge 1 when an operand is zero, and after edge 8 otherwise (default multi-cycle variant, six digits).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiply; taken only while idle |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| busy | output | 1 | High while a multiply is in progress |
| done | output | 1 | One-cycle pulse: result and flags valid |
| result | output | 32 | Packed product word |
| cc_ovf | output | 1 | Exponent left the representable range |
| cc_neg | output | 1 | Result negative (including negative saturation) |
| cc_pos | output | 1 | Result positive and nonzero, or positive saturation |

## Verification
The hardest case to reach is the rounding carry that spills out of the 24-bit fraction. Only a narrow set of fraction pairs, such as 0x3FFFFF and 0x400001, produce it, so the bench applies that pair directly. The exponent boundaries at 0, 1, 127 and 128 also need exact operand choices, and the bench drives them with 0x800000 fractions whose product has a known leading digit. The third hard case is a start pulse that lands in the middle of a running operation. The bench times it to the edge after acceptance and then watches for a spurious second completion. A near-exhaustive sweep over signs, unnormalized fractions and edge exponents covers the rest against an arithmetic model.

// File: rtl/hfm_pkg.sv
package hfm_pkg;
   // Width of one hexadecimal digit of the fraction.
   localparam int unsigned DIGIT_W = 4;
   // Extra leading digits of the double-width product over the fraction.
   localparam int unsigned HEAD_DIGITS = 2;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_MUL  = 1'b1
   } hfm_state_e;
endpackage

// File: rtl/hfm_unpack.sv
module hfm_unpack #(
   parameter int EXP_W  = 7,
   parameter int DIGITS = 6,
   parameter int EXPI_W = EXP_W + 4
) (
   input  logic [1+EXP_W+DIGITS*hfm_pkg::DIGIT_W-1:0] word,
   output logic                                       sign,
   output logic signed [EXPI_W-1:0]                   exp_n,
   output logic [DIGITS*hfm_pkg::DIGIT_W-1:0]         frac_n,
   output logic                                       is_zero
);
   localparam int FRAC_W = DIGITS * hfm_pkg::DIGIT_W;
   localparam int LZ_W   = $clog2(DIGITS + 1);

   logic [FRAC_W-1:0]        raw;
   logic [LZ_W-1:0]          lz;
   logic                     found;
   logic signed [EXPI_W-1:0] e_raw;
   logic signed [EXPI_W-1:0] e_lz;

   assign raw = word[FRAC_W-1:0];

   // Count leading zero hex digits of the raw fraction.
   always_comb begin
      lz    = '0;
      found = 1'b0;
      for (int d = DIGITS - 1; d >= 0; d--) begin
         if (!found) begin
            if (raw[d*hfm_pkg::DIGIT_W +: hfm_pkg::DIGIT_W] != '0) found = 1'b1;
            else                                                 lz = lz + 1'b1;
         end
      end
   end

   assign is_zero = (raw == '0);
   assign e_raw   = EXPI_W'(word[FRAC_W +: EXP_W]);
   assign e_lz    = EXPI_W'(lz);
   assign frac_n  = raw << {lz, 2'b00};
   assign exp_n   = is_zero ? '0 : (e_raw - e_lz);
   assign sign    = is_zero ? 1'b0 : word[FRAC_W+EXP_W];
endmodule

// File: rtl/hfm_mul_core.sv
module hfm_mul_core #(
   parameter int DIGITS    = 6,
   parameter bit ITERATIVE = 1'b1
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   load,
   input  logic [DIGITS*hfm_pkg::DIGIT_W-1:0]     a,
   input  logic [DIGITS*hfm_pkg::DIGIT_W-1:0]     b,
   output logic [2*DIGITS*hfm_pkg::DIGIT_W-1:0]   prod,
   output logic                                   prod_valid
);
   localparam int DW     = hfm_pkg::DIGIT_W;
   localparam int FRAC_W = DIGITS * DW;
   localparam int PROD_W = 2 * FRAC_W;
   localparam int PW     = FRAC_W + DW;
   localparam int CNT_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1;

   generate
      if (ITERATIVE) begin : g_serial
         logic [FRAC_W-1:0] mcand;
         logic [FRAC_W-1:0] mplier;
         logic [PROD_W-1:0] acc;
         logic [CNT_W-1:0]  cnt;
         logic              run;
         logic [PW-1:0]     partial;

         // One multiplier digit per cycle; accumulator moves right one digit.
         assign partial = PW'(acc[PROD_W-1:FRAC_W]) + PW'(mcand) * PW'(mplier[DW-1:0]);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mcand      <= '0;
               mplier     <= '0;
               acc        <= '0;
               cnt        <= '0;
               run        <= 1'b0;
               prod_valid <= 1'b0;
            end else begin
               prod_valid <= 1'b0;
               if (load) begin
                  mcand  <= a;
                  mplier <= b;
                  acc    <= '0;
                  cnt    <= '0;
                  run    <= 1'b1;
               end else if (run) begin
                  acc    <= {partial, acc[FRAC_W-1:DW]};
                  mplier <= mplier >> DW;
                  cnt    <= cnt + 1'b1;
                  if (cnt == CNT_W'(DIGITS - 1)) begin
                     run        <= 1'b0;
                     prod_valid <= 1'b1;
                  end
               end
            end
         end
         assign prod = acc;

         p_step_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
            run |-> (int'(cnt) < DIGITS));
         p_valid_after_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
            prod_valid |-> $past(run));
      end else begin : g_array
         logic [PROD_W-1:0] acc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc        <= '0;
               prod_valid <= 1'b0;
            end else begin
               prod_valid <= load;
               if (load) acc <= PROD_W'(a) * PROD_W'(b);
            end
         end
         assign prod = acc;
      end
   endgenerate
endmodule

// File: rtl/hfm_round_pack.sv
module hfm_round_pack #(
   parameter int EXP_W  = 7,
   parameter int DIGITS = 6,
   parameter int EXPI_W = EXP_W + 4
) (
   input  logic                                     sign,
   input  logic signed [EXPI_W-1:0]                 exp_sum,
   input  logic [2*DIGITS*hfm_pkg::DIGIT_W-1:0]     prod,
   output logic [1+EXP_W+DIGITS*hfm_pkg::DIGIT_W-1:0] word,
   output logic                                     ovf,
   output logic                                     neg,
   output logic                                     pos
);
   localparam int DW     = hfm_pkg::DIGIT_W;
   localparam int FRAC_W = DIGITS * DW;
   localparam int PROD_W = 2 * FRAC_W;
   localparam int LZ_W   = $clog2(2 * DIGITS + 1);
   localparam logic signed [EXPI_W-1:0] BIAS_S    = EXPI_W'(1 << (EXP_W - 1));
   localparam logic signed [EXPI_W-1:0] HEAD_S    = EXPI_W'(hfm_pkg::HEAD_DIGITS);
   localparam logic signed [EXPI_W-1:0] EXP_MAX_S = EXPI_W'((1 << EXP_W) - 1);

   logic [LZ_W-1:0]          lz;
   logic                     found;
   logic [PROD_W-1:0]        norm;
   logic [FRAC_W:0]          inc;
   logic [FRAC_W-1:0]        frac_fin;
   logic signed [EXPI_W-1:0] lz_s;
   logic signed [EXPI_W-1:0] e_norm;
   logic signed [EXPI_W-1:0] e_fin;
   logic                     under;
   logic                     over;
   logic                     unused_low;

   // Leading zero digits of the double-width product.
   always_comb begin
      lz    = '0;
      found = 1'b0;
      for (int d = 2 * DIGITS - 1; d >= 0; d--) begin
         if (!found) begin
            if (prod[d*DW +: DW] != '0) found = 1'b1;
            else                         lz = lz + 1'b1;
         end
      end
   end

   assign norm       = prod << {lz, 2'b00};
   assign unused_low = ^{norm[FRAC_W-2:0], inc[DW-1:0]};
   assign lz_s       = EXPI_W'(lz);
   // Product exponent carries two head digits, then the digit shift removes them.
   assign e_norm     = exp_sum - BIAS_S + HEAD_S - (HEAD_S + lz_s);
   assign inc        = {1'b0, norm[PROD_W-1:FRAC_W]} + (FRAC_W+1)'(norm[FRAC_W-1]);

   always_comb begin
      if (inc[FRAC_W]) begin
         frac_fin = {{(DW-1){1'b0}}, inc[FRAC_W:DW]};
         e_fin    = e_norm + EXPI_W'(1);
      end else begin
         frac_fin = inc[FRAC_W-1:0];
         e_fin    = e_norm;
      end
   end

   assign under = e_fin[EXPI_W-1] || (e_fin == '0);
   assign over  = !e_fin[EXPI_W-1] && (e_fin > EXP_MAX_S);

   always_comb begin
      if (prod == '0) begin
         word = '0;
         ovf  = 1'b0;
         neg  = 1'b0;
         pos  = 1'b0;
      end else if (under) begin
         word = '0;
         ovf  = 1'b1;
         neg  = 1'b0;
         pos  = 1'b0;
      end else if (over) begin
         word = {sign, {(EXP_W+FRAC_W){1'b1}}};
         ovf  = 1'b1;
         neg  = sign;
         pos  = !sign;
      end else begin
         word = {sign, e_fin[EXP_W-1:0], frac_fin};
         ovf  = 1'b0;
         neg  = sign;
         pos  = !sign;
      end
   end
endmodule

// File: rtl/hfm_mul.sv
module hfm_mul #(
   parameter int EXP_W     = 7,
   parameter int DIGITS    = 6,
   parameter bit ITERATIVE = 1'b1,
   parameter int WORD_W    = 1 + EXP_W + DIGITS * 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] result,
   output logic              cc_ovf,
   output logic              cc_neg,
   output logic              cc_pos
);
   import hfm_pkg::*;

   localparam int FRAC_W = DIGITS * DIGIT_W;
   localparam int PROD_W = 2 * FRAC_W;
   localparam int EXPI_W = EXP_W + 4;

   generate
      if (DIGITS < 2 || DIGITS > 16) begin : g_bad_digits
         $error("hfm_mul: DIGITS must lie in 2..16");
      end
      if (EXP_W < 3 || EXP_W > 16) begin : g_bad_exp
         $error("hfm_mul: EXP_W must lie in 3..16");
      end
      if (WORD_W != 1 + EXP_W + DIGITS * DIGIT_W) begin : g_bad_word
         $error("hfm_mul: WORD_W does not match EXP_W and DIGITS");
      end
   endgenerate

   logic [WORD_W-1:0]        opw   [2];
   logic                     sgn_u [2];
   logic signed [EXPI_W-1:0] exp_u [2];
   logic [FRAC_W-1:0]        frc_u [2];
   logic                     zer_u [2];

   assign opw[0] = op_a;
   assign opw[1] = op_b;

   generate
      for (genvar i = 0; i < 2; i++) begin : g_unpack
         hfm_unpack #(.EXP_W(EXP_W), .DIGITS(DIGITS), .EXPI_W(EXPI_W)) u_unpack (
            .word    (opw[i]),
            .sign    (sgn_u[i]),
            .exp_n   (exp_u[i]),
            .frac_n  (frc_u[i]),
            .is_zero (zer_u[i])
         );
      end
   endgenerate

   hfm_state_e               state;
   logic                     sign_r;
   logic signed [EXPI_W-1:0] esum_r;
   logic                     accept;
   logic                     any_zero;
   logic                     load;
   logic [PROD_W-1:0]        prod;
   logic                     prod_valid;
   logic [WORD_W-1:0]        pk_word;
   logic                     pk_ovf;
   logic                     pk_neg;
   logic                     pk_pos;

   assign accept   = (state == ST_IDLE) && start;
   assign any_zero = zer_u[0] || zer_u[1];
   assign load     = accept && !any_zero;
   assign busy     = (state != ST_IDLE);

   hfm_mul_core #(.DIGITS(DIGITS), .ITERATIVE(ITERATIVE)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .a          (frc_u[0]),
      .b          (frc_u[1]),
      .prod       (prod),
      .prod_valid (prod_valid)
   );

   hfm_round_pack #(.EXP_W(EXP_W), .DIGITS(DIGITS), .EXPI_W(EXPI_W)) u_pack (
      .sign    (sign_r),
      .exp_sum (esum_r),
      .prod    (prod),
      .word    (pk_word),
      .ovf     (pk_ovf),
      .neg     (pk_neg),
      .pos     (pk_pos)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         sign_r <= 1'b0;
         esum_r <= '0;
         done   <= 1'b0;
         result <= '0;
         cc_ovf <= 1'b0;
         cc_neg <= 1'b0;
         cc_pos <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  sign_r <= sgn_u[0] ^ sgn_u[1];
                  esum_r <= exp_u[0] + exp_u[1];
                  if (any_zero) begin
                     result <= '0;
                     cc_ovf <= 1'b0;
                     cc_neg <= 1'b0;
                     cc_pos <= 1'b0;
                     done   <= 1'b1;
                  end else begin
                     state <= ST_MUL;
                  end
               end
            end
            ST_MUL: begin
               if (prod_valid) begin
                  result <= pk_word;
                  cc_ovf <= pk_ovf;
                  cc_neg <= pk_neg;
                  cc_pos <= pk_pos;
                  done   <= 1'b1;
                  state  <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(esum_r) && $stable(sign_r)));
   p_zero_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result == '0) |-> (!cc_neg && !cc_pos));
   p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cc_ovf) |-> ((result[WORD_W-2:0] == '0) || (&result[WORD_W-2:0])));
   p_flag_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cc_neg, cc_pos}));
   p_normalized_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cc_ovf && result != '0) |-> (result[FRAC_W-1 -: DIGIT_W] != '0));
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> (done || $stable(result)));
endmodule

// File: tb/hfm_mul_test.sv
`timescale 1ns/1ps
module hfm_mul_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic        busy, done, cc_ovf, cc_neg, cc_pos;
   logic [31:0] result;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   hfm_mul uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
      .busy(busy), .done(done), .result(result),
      .cc_ovf(cc_ovf), .cc_neg(cc_neg), .cc_pos(cc_pos)
   );

   logic [6:0]  sw_exp  [6] = '{7'd0, 7'd1, 7'd32, 7'd64, 7'd96, 7'd127};
   logic [23:0] sw_frac [8] = '{24'h000000, 24'h000001, 24'h00F000, 24'h100000,
                                24'h3FFFFF, 24'h400001, 24'h800000, 24'hFFFFFF};

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Arithmetic model built from the requirements.
   task automatic model(input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] w, output logic [2:0] cc);
      longint fa, fb, p, frac, rb;
      int ea, eb, e;
      logic s;
      fa = longint'(a[23:0]);
      fb = longint'(b[23:0]);
      if (fa == 0 || fb == 0) begin
         w = '0; cc = 3'b000;
         return;
      end
      ea = int'(a[30:24]);
      eb = int'(b[30:24]);
      while (fa < 64'h100000) begin fa = fa * 16; ea--; end
      while (fb < 64'h100000) begin fb = fb * 16; eb--; end
      s = a[31] ^ b[31];
      p = fa * fb;
      e = ea + eb - 64;
      while (p < 64'h1000_0000_0000) begin p = p * 16; e--; end
      frac = p >> 24;
      rb   = (p >> 23) & 1;
      frac = frac + rb;
      if (frac >= 64'h1000000) begin frac = frac / 16; e++; end
      if (e <= 0) begin
         w = '0; cc = 3'b100;
      end else if (e > 127) begin
         w = {s, 31'h7FFFFFFF}; cc = {1'b1, s, !s};
      end else begin
         w = {s, 7'(e), 24'(frac)}; cc = {1'b0, s, !s};
      end
   endtask

   task automatic run_op(input logic [31:0] a, input logic [31:0] b, input string req);
      logic [31:0] ew;
      logic [2:0]  ecc;
      int n, lat;
      model(a, b, ew, ecc);
      lat = (a[23:0] == 0 || b[23:0] == 0) ? 1 : 8;
      @(negedge clk);
      op_a = a; op_b = b; start = 1'b1;
      @(posedge clk);
      n = 1;
      #1 start = 1'b0;
      while (!done && n < 40) begin
         @(posedge clk);
         n++;
         #1;
      end
      check(n == lat, "R11 latency", 64'(n), 64'(lat));
      check(result == ew, req, {32'h0, result}, {32'h0, ew});
      check({cc_ovf, cc_neg, cc_pos} == ecc, req, 64'({cc_ovf, cc_neg, cc_pos}), 64'(ecc));
      @(posedge clk); #1;
      check(!done, "R9 pulse", 64'(done), 64'd0);
   endtask

   initial begin
      #(5.0 * 190000);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check({done, busy, cc_ovf, cc_neg, cc_pos} == 5'b0, "R9 reset flags",
            64'({done, busy, cc_ovf, cc_neg, cc_pos}), 64'd0);
      check(result == '0, "R9 reset result", 64'(result), 64'd0);
      @(negedge clk) rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // Directed cases with hand-derived constants.
      run_op(32'h403FFFFF, 32'h40400001, "R5 round carry");
      check(result == 32'h40100000, "R5 constant", 64'(result), 64'h40100000);
      run_op(32'hC5000000, 32'h41123456, "R2 zero operand");
      check(result == 32'h0 && !cc_ovf, "R2 constant", 64'(result), 64'h0);
      run_op(32'h42000010, 32'h41100000, "R1 unnormalized");
      check(result == 32'h3E100000, "R1 constant", 64'(result), 64'h3E100000);
      run_op(32'hC1200000, 32'h41300000, "R3 sign");
      check(result == 32'hC1600000 && cc_neg, "R3 constant", 64'(result), 64'hC1600000);
      run_op(32'h01100000, 32'h01100000, "R6 underflow");
      check(cc_ovf && result == 0, "R6 constant", 64'(result), 64'h0);
      run_op(32'h20800000, 32'h20800000, "R6 exponent zero");
      check(cc_ovf && result == 0, "R6 boundary", 64'(result), 64'h0);
      run_op(32'h20800000, 32'h21800000, "R8 exponent one");
      check(result == 32'h01400000, "R8 boundary low", 64'(result), 64'h01400000);
      run_op(32'h5F800000, 32'h60800000, "R8 exponent max");
      check(result == 32'h7F400000, "R8 boundary high", 64'(result), 64'h7F400000);
      run_op(32'h60800000, 32'h60800000, "R7 exponent above max");
      check(result == 32'h7FFFFFFF && cc_pos, "R7 positive", 64'(result), 64'h7FFFFFFF);
      run_op(32'hFF100000, 32'h7F100000, "R7 negative saturation");
      check(result == 32'hFFFFFFFF && cc_neg, "R7 negative", 64'(result), 64'hFFFFFFFF);

      // R10: start during a running operation is ignored.
      begin
         logic [31:0] ew;
         logic [2:0]  ecc;
         int n, extra;
         model(32'h41300000, 32'h41200000, ew, ecc);
         @(negedge clk);
         op_a = 32'h41300000; op_b = 32'h41200000; start = 1'b1;
         @(posedge clk); n = 1;
         #1 start = 1'b0;
         check(busy, "R10 busy", 64'(busy), 64'd1);
         @(negedge clk);
         op_a = 32'h7F100000; op_b = 32'hC2000000; start = 1'b1;
         @(posedge clk); n++;
         #1 start = 1'b0;
         while (!done && n < 40) begin @(posedge clk); n++; #1; end
         check(n == 8, "R10 latency", 64'(n), 64'd8);
         check(result == ew, "R10 result", 64'(result), 64'(ew));
         extra = 0;
         for (int k = 0; k < 12; k++) begin
            @(posedge clk); #1;
            if (done) extra++;
            check(result == ew, "R9 hold", 64'(result), 64'(ew));
         end
         check(extra == 0, "R10 no second done", 64'(extra), 64'd0);
      end

      // R4 sweep: signs, edge exponents, unnormalized and zero fractions.
      for (int ia = 0; ia < 96; ia++) begin
         for (int ib = 0; ib < 96; ib++) begin
            run_op({ia[0], sw_exp[ia / 16], sw_frac[(ia / 2) % 8]},
                   {ib[0], sw_exp[ib / 16], sw_frac[(ib / 2) % 8]}, "R4 sweep");
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule